// File: doc/BRIEF.md
# Truncated-Range Down Counter

This block is a synchronous down counter whose count runs from a ceiling value down to a floor value and then starts again at the ceiling. It never passes through zero. With the default settings it counts 7, 6, 5, 4, 3 and then returns to 7. The value 2 and lower never appear on the output. The ceiling, the floor and the counter width are parameters.

All state changes happen on the falling edge of the single clock. The return to the ceiling is decided by the next-state logic. It is not produced by an asynchronous preset, so the output never shows a transient value below the floor. A strobe marks the cycle in which the next enabled edge will reload the ceiling. An active-low asynchronous reset places the counter at the ceiling. A count-enable input freezes the counter when it is low.

Top module: `trunc_down_counter`

## Requirements
- R1: While `rst_ni` is low, `count_o` equals MAX (default 7) and `reload_o` is low. This holds immediately, without waiting for a clock edge.
- R2: On a falling clock edge with `en_i` high and `count_o` above LAST, the count decreases by exactly one.
- R3: On a falling clock edge with `en_i` high and `count_o` equal to LAST (default 3), the count becomes MAX. It does not become LAST-1 or zero.
- R4: `reload_o` is high exactly when `en_i` is high and `count_o` equals LAST. It is combinational in these two signals.
- R5: While `en_i` is low, the count keeps its value across falling edges and `reload_o` stays low, even when the count equals LAST.
- R6: After reset, `count_o` always lies between LAST and MAX inclusive. With enable held high, the sequence repeats every MAX-LAST+1 enabled edges. With the defaults this is 7, 6, 5, 4, 3, 7.
- R7: The width, ceiling and floor can be set by parameters. A 4-bit instance with MAX=12 and LAST=9 counts 12, 11, 10, 9, 12 and strobes at 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; state changes on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low; loads MAX |
| en_i | input | 1 | Count enable |
| count_o | output | WIDTH | Current count |
| reload_o | output | 1 | High in the cycle whose enabled edge reloads MAX |

## Verification
Two events can coincide with the pending reload:

- **Enable drops on the floor.** The bench lowers `en_i` in the very cycle the count sits on LAST. This must both hold the count and suppress the strobe. It is judged by sampling `reload_o` a moment after the enable change, and the count at the following rising edge.
- **Reset before the reload edge.** The bench asserts reset after the count reaches LAST with enable high, before the falling edge that would reload. The count must show MAX at once, and no reload pulse may remain afterwards.

A second instance with different parameters runs on the same enable pattern. Its floor is reached in different cycles, so a reload in one instance coincides with a plain decrement in the other.

// File: rtl/trunc_dcnt_pkg.sv
`timescale 1ns/1ps
package trunc_dcnt_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_STEP   = 2'd1,
    ACT_RELOAD = 2'd2
  } dcnt_act_e;
endpackage

// File: rtl/trunc_dcnt_term.sv
`timescale 1ns/1ps
module trunc_dcnt_term #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned LAST  = 3
) (
  input  logic [WIDTH-1:0] count_i,
  input  logic             en_i,
  output logic             at_last_o,
  output logic             reload_o
);
  localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LAST);

  always_comb begin
    at_last_o = (count_i == LAST_V);
    reload_o  = en_i & at_last_o;
  end
endmodule

// File: rtl/trunc_dcnt_next.sv
`timescale 1ns/1ps
module trunc_dcnt_next
  import trunc_dcnt_pkg::*;
#(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned MAX   = 7,
  parameter int unsigned LAST  = 3
) (
  input  logic [WIDTH-1:0] count_i,
  input  logic             en_i,
  input  logic             at_last_i,
  output dcnt_act_e        act_o,
  output logic [WIDTH-1:0] next_o
);
  localparam logic [WIDTH-1:0] MAX_V  = WIDTH'(MAX);
  localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LAST);

  logic out_of_range;

  // unreachable codes recover to the ceiling on the next enabled edge
  always_comb begin
    out_of_range = (count_i < LAST_V) || (count_i > MAX_V);
    if (!en_i)                          act_o = ACT_HOLD;
    else if (at_last_i || out_of_range) act_o = ACT_RELOAD;
    else                                act_o = ACT_STEP;
  end

  always_comb begin
    unique case (act_o)
      ACT_STEP:   next_o = count_i - WIDTH'(1);
      ACT_RELOAD: next_o = MAX_V;
      default:    next_o = count_i;
    endcase
  end
endmodule

// File: rtl/trunc_dcnt_reg.sv
`timescale 1ns/1ps
module trunc_dcnt_reg #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned MAX   = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam logic [WIDTH-1:0] MAX_V = WIDTH'(MAX);

  // state advances on the high-to-low clock transition
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= MAX_V;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/trunc_down_counter.sv
`timescale 1ns/1ps
module trunc_down_counter
  import trunc_dcnt_pkg::*;
#(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned MAX   = 7,
  parameter int unsigned LAST  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [WIDTH-1:0] count_o,
  output logic             reload_o
);
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             at_last;
  logic             strobe;
  dcnt_act_e        act;

  trunc_dcnt_term #(.WIDTH(WIDTH), .LAST(LAST)) u_term (
    .count_i   (cnt_q),
    .en_i      (en_i),
    .at_last_o (at_last),
    .reload_o  (strobe)
  );

  trunc_dcnt_next #(.WIDTH(WIDTH), .MAX(MAX), .LAST(LAST)) u_next (
    .count_i   (cnt_q),
    .en_i      (en_i),
    .at_last_i (at_last),
    .act_o     (act),
    .next_o    (cnt_d)
  );

  trunc_dcnt_reg #(.WIDTH(WIDTH), .MAX(MAX)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (act != ACT_HOLD),
    .d_i    (cnt_d),
    .q_o    (cnt_q)
  );

  assign count_o  = cnt_q;
  assign reload_o = strobe & rst_ni;
endmodule

// File: rtl/trunc_down_counter_chk.sv
`timescale 1ns/1ps
module trunc_down_counter_chk #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned MAX   = 7,
  parameter int unsigned LAST  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [WIDTH-1:0] count_o,
  input logic             reload_o
);
  localparam logic [WIDTH-1:0] MAX_V  = WIDTH'(MAX);
  localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LAST);

  p_reset_max_r1: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> count_o == MAX_V);

  p_step_down_r2: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (en_i && count_o != LAST_V) |=> count_o == WIDTH'($past(count_o) - WIDTH'(1)));

  p_reload_max_r3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (en_i && count_o == LAST_V) |=> count_o == MAX_V);

  p_strobe_then_max_r4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    reload_o |=> count_o == MAX_V);

  p_hold_r5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(count_o));

  p_quiet_strobe_r5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !en_i |-> !reload_o);

  p_in_range_r6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    count_o >= LAST_V && count_o <= MAX_V);
endmodule

bind trunc_down_counter trunc_down_counter_chk #(
  .WIDTH(WIDTH), .MAX(MAX), .LAST(LAST)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .count_o  (count_o),
  .reload_o (reload_o)
);

// File: tb/trunc_down_counter_tb_top.sv
`timescale 1ns/1ps
module trunc_down_counter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b1;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [2:0] cnt_a;
  logic       rl_a;
  logic [3:0] cnt_b;
  logic       rl_b;

  int checks = 0;
  int fails  = 0;
  int ma = 7;
  int mb = 12;
  bit done = 0;

  typedef struct packed {
    logic [2:0] a_cnt;
    logic       a_rl;
    logic [3:0] b_cnt;
    logic       b_rl;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  trunc_down_counter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .count_o(cnt_a), .reload_o(rl_a)
  );

  // R7: alternate parameter set
  trunc_down_counter #(.WIDTH(4), .MAX(12), .LAST(9)) dut_b_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .count_o(cnt_b), .reload_o(rl_b)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  function automatic int nxt(int c, bit e, int mx, int ls);
    if (!e) return c;
    if (c <= ls || c > mx) return mx;
    return c - 1;
  endfunction

  // driver: called just after a rising edge
  task automatic step(bit e);
    exp_t it;
    #1 en = e;
    #1;
    chk("R4/R5 strobe a", int'(rl_a), int'(e && ma == 3));
    chk("R4/R7 strobe b", int'(rl_b), int'(e && mb == 9));
    ma = nxt(ma, e, 7, 3);
    mb = nxt(mb, e, 12, 9);
    it.a_cnt = 3'(ma);
    it.a_rl  = e && ma == 3;
    it.b_cnt = 4'(mb);
    it.b_rl  = e && mb == 9;
    q.push_back(it);
    @(posedge clk);
  endtask

  // monitor: rising edge is away from the active falling edge
  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      chk("R2/R3/R5 count a", int'(cnt_a), int'(it.a_cnt));
      chk("R4 strobe a", int'(rl_a), int'(it.a_rl));
      chk("R7 count b", int'(cnt_b), int'(it.b_cnt));
      chk("R7 strobe b", int'(rl_b), int'(it.b_rl));
      chk("R6 range a", int'(cnt_a >= 3 && cnt_a <= 7), 1);
    end
  end

  task automatic mid_reset();
    #1 rst_n = 1'b0;
    #1;
    chk("R1 async reset a", int'(cnt_a), 7);
    chk("R1 async reset b", int'(cnt_b), 12);
    chk("R1 strobe low a", int'(rl_a), 0);
    ma = 7;
    mb = 12;
    en = 1'b0;
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    // R1: reset state, enable high has no effect while in reset
    en = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;
    chk("R1 reset count a", int'(cnt_a), 7);
    chk("R1 reset strobe a", int'(rl_a), 0);
    chk("R1 reset count b", int'(cnt_b), 12);
    en = 1'b0;
    #1 rst_n = 1'b1;
    @(posedge clk);

    // R2 R3 R6: two full enabled laps, 010 must never appear
    for (int i = 0; i < 12; i++) step(1'b1);

    // R5: drive to the floor, then drop enable while sitting on it
    while (ma != 3) step(1'b1);
    for (int i = 0; i < 3; i++) step(1'b0);
    step(1'b1);
    chk("R3 reload after hold a", int'(cnt_a), 7);

    // mixed enable pattern
    for (int i = 0; i < 16; i++) step(1'(((i * 5) % 3) != 0));

    // reset arriving while a reload is pending
    while (ma != 3) step(1'b1);
    mid_reset();
    for (int i = 0; i < 6; i++) step(1'b1);

    // drain the last expectation
    @(posedge clk);
    #1;
    finish_run();
  end
endmodule